// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block arbitrates among a group of packet queues that feed one output port. Every queue holds a configuration code. Codes 0 to 8 are weights, and each weight maps to a fixed 8-bit round-participation mask whose set bits are spread evenly. Code 9 places the queue in a static-priority group, and the group is always served ahead of the weighted queues. The scheduler steps through eight rounds. In round r, a weighted queue may be granted only if bit r of its mask is set and it has data pending. Each queue is granted at most once per round.

Software-side logic writes one queue's code at a time through a write port. A write that uses an illegal code, or that would leave the static group with a gap or not starting at queue 0, is refused with a one-cycle error pulse, and the old configuration stays. Codes may be rewritten while arbitration is running. A consumer holds `req` high while it can accept grants. Each accepted decision is returned one cycle later as a valid strobe with a one-hot vector and a binary index.

The controller has two named states. ST_IDLE is entered whenever `req` was low on the previous edge. ST_SCAN is entered whenever `req` was high. Decisions are made only in ST_SCAN while `req` is still high, and each decision takes one of three outcomes:
- PK_STATIC grants the lowest pending static queue.
- PK_WEIGHTED grants the next eligible queue at or above the scan pointer. Granting the last queue also closes the round.
- PK_NONE advances to the next round and resets the scan pointer to 0.

Top module: `wrr_sched`

## Requirements
- R1: After reset, no grant and no error are signalled, the round is 0, the scan pointer is 0 and every queue's mask is 0x00, so no queue is granted until it is configured.
- R2: Weight codes map to masks as 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF, where bit r enables round r. Within a round, eligible queues are granted in ascending index order starting from the scan pointer.
- R3: When all queues are backlogged and no queue is static, eight consecutive rounds starting at round 0 grant each queue exactly as many times as its weight.
- R4: A queue with weight 0 that is not static is never granted.
- R5: Whenever any static queue has data pending, the lowest-numbered pending static queue is granted, and the round and scan pointer are left unchanged.
- R6: Code 9 makes a queue static, with mask 0xFF. Any write that would leave the static set non-contiguous or not starting at queue 0 raises `cfg_err` in the cycle after the write, and the previous configuration is kept.
- R7: Codes 10 to 15 raise `cfg_err` in the cycle after the write and change nothing.
- R8: When no queue is eligible in the current round, the round advances by one each decision cycle, wrapping 7→0. A backlogged queue with a nonzero mask is therefore granted within 12 cycles of the previous grant.
- R9: While `req` is low, no grant is issued and the round and scan pointer hold their values.
- R10: `gnt_valid` comes with a one-hot `gnt_onehot` that matches `gnt_idx`, and the granted queue had data pending at the decision edge.
- R11: A code written while arbitration is running takes effect from the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_pending | input | NQ | Per-queue data-pending flags |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | QW | Queue selected by the write |
| cfg_code | input | 4 | Weight 0-8, or 9 for static priority |
| req | input | 1 | Consumer asks for grants |
| gnt_valid | output | 1 | A grant is presented this cycle |
| gnt_onehot | output | NQ | One-hot granted queue |
| gnt_idx | output | QW | Binary index of granted queue |
| cfg_err | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench sweeps every weight across a four-queue group and checks both the exact grant order and the per-queue grant counts. A mask table with a misplaced bit would reorder or miscount grants. Scheduling a queue twice within one round would inflate its count. A static write that leaves a gap, or a static group that does not start at queue 0, must be refused; a design that accepted such a write would start granting the wrong queue. The bench also pauses `req` in the middle of a round, rewrites weights mid-run, and gives a single queue weight 1 so that seven empty rounds have to be skipped. A design that lost its round position, or that skipped rounds too slowly, would break the modelled sequence or the grant-gap bound.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    localparam int ROUNDS = 8;
    localparam logic [3:0] CODE_STATIC = 4'd9;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SCAN
    } sched_state_t;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_STATIC,
        PK_WEIGHTED
    } pick_kind_t;

    // evenly spread participation masks, bit r = round r
    function automatic logic [ROUNDS-1:0] code_to_mask(input logic [3:0] code);
        logic [ROUNDS-1:0] m;
        case (code)
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h11;
            4'd3:    m = 8'h49;
            4'd4:    m = 8'h55;
            4'd5:    m = 8'h57;
            4'd6:    m = 8'h77;
            4'd7:    m = 8'h7F;
            4'd8:    m = 8'hFF;
            4'd9:    m = 8'hFF;
            default: m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wrr_cfg_table.sv
module wrr_cfg_table
    import wrr_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QW = $clog2(NQ)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [QW-1:0]                idx,
    input  logic [3:0]                   code,
    output logic [NQ-1:0][ROUNDS-1:0]    masks,
    output logic [NQ-1:0]                stat,
    output logic                         err
);

    logic [NQ-1:0] nxt_stat;
    logic          idx_ok;
    logic          code_ok;
    logic          grp_ok;
    logic          accept;

    always_comb begin
        idx_ok   = ({1'b0, idx} < (QW+1)'(NQ));
        code_ok  = (code <= CODE_STATIC);
        nxt_stat = stat;
        if (idx_ok) nxt_stat[idx] = (code == CODE_STATIC);
        // contiguous from bit 0 means value is 2^k-1
        grp_ok   = ((nxt_stat & (nxt_stat + {{(NQ-1){1'b0}}, 1'b1})) == '0);
        accept   = we && idx_ok && code_ok && grp_ok;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [ROUNDS-1:0] mask_q;
        logic              stat_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                stat_q <= 1'b0;
            end else if (accept && (idx == QW'(g))) begin
                mask_q <= code_to_mask(code);
                stat_q <= (code == CODE_STATIC);
            end
        end
        assign masks[g] = mask_q;
        assign stat[g]  = stat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= we && !accept;
    end

    assert_group_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & (stat + {{(NQ-1){1'b0}}, 1'b1})) == '0);

    assert_reject_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(stat) && $stable(masks)));

endmodule

// File: rtl/wrr_pick.sv
module wrr_pick #(
    parameter int NQ = 4,
    localparam int QW = $clog2(NQ)
) (
    input  logic [NQ-1:0] vec,
    input  logic [QW-1:0] start,
    output logic          found,
    output logic [QW-1:0] idx
);

    // lowest set bit at or above start
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (vec[i] && (QW'(i) >= start)) begin
                found = 1'b1;
                idx   = QW'(i);
            end
        end
    end

endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
    import wrr_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QW = $clog2(NQ),
    localparam int RW = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] q_pending,
    input  logic          cfg_we,
    input  logic [QW-1:0] cfg_idx,
    input  logic [3:0]    cfg_code,
    input  logic          req,
    output logic          gnt_valid,
    output logic [NQ-1:0] gnt_onehot,
    output logic [QW-1:0] gnt_idx,
    output logic          cfg_err
);

    logic [NQ-1:0][ROUNDS-1:0] masks;
    logic [NQ-1:0]             stat;
    logic [NQ-1:0]             elig;
    logic [NQ-1:0]             stat_pend;
    logic [RW-1:0]             rnd;
    logic [QW-1:0]             scan_ptr;
    logic                      s_found, w_found;
    logic [QW-1:0]             s_idx, w_idx;
    pick_kind_t                kind;
    sched_state_t              state;

    wrr_cfg_table #(.NQ(NQ)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .code  (cfg_code),
        .masks (masks),
        .stat  (stat),
        .err   (cfg_err)
    );

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            elig[i] = q_pending[i] && masks[i][rnd];
        end
        stat_pend = q_pending & stat;
    end

    wrr_pick #(.NQ(NQ)) i_pick_static (
        .vec   (stat_pend),
        .start ('0),
        .found (s_found),
        .idx   (s_idx)
    );

    wrr_pick #(.NQ(NQ)) i_pick_weighted (
        .vec   (elig),
        .start (scan_ptr),
        .found (w_found),
        .idx   (w_idx)
    );

    always_comb begin
        if (s_found)      kind = PK_STATIC;
        else if (w_found) kind = PK_WEIGHTED;
        else              kind = PK_NONE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= req ? ST_SCAN : ST_IDLE;
    end

    // decision and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd        <= '0;
            scan_ptr   <= '0;
            gnt_valid  <= 1'b0;
            gnt_onehot <= '0;
            gnt_idx    <= '0;
        end else begin
            gnt_valid  <= 1'b0;
            gnt_onehot <= '0;
            unique case (state)
                ST_IDLE: begin
                end
                ST_SCAN: begin
                    if (req) begin
                        unique case (kind)
                            PK_STATIC: begin
                                gnt_valid  <= 1'b1;
                                gnt_idx    <= s_idx;
                                gnt_onehot <= NQ'(1) << s_idx;
                            end
                            PK_WEIGHTED: begin
                                gnt_valid  <= 1'b1;
                                gnt_idx    <= w_idx;
                                gnt_onehot <= NQ'(1) << w_idx;
                                if (w_idx == QW'(NQ - 1)) begin
                                    rnd      <= rnd + RW'(1);
                                    scan_ptr <= '0;
                                end else begin
                                    scan_ptr <= w_idx + QW'(1);
                                end
                            end
                            PK_NONE: begin
                                rnd      <= rnd + RW'(1);
                                scan_ptr <= '0;
                            end
                            default: begin
                            end
                        endcase
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt_onehot) == 1 && gnt_onehot[gnt_idx]));

    assert_grant_was_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (($past(q_pending) & gnt_onehot) != '0));

    assert_static_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && ($past(q_pending & stat) != '0)) |->
            (($past(q_pending & stat) & gnt_onehot) != '0));

    assert_round_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd != $past(rnd)) |-> (rnd == $past(rnd) + RW'(1)));

    assert_no_grant_without_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req) |-> (!gnt_valid && $stable(rnd) && $stable(scan_ptr)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (gnt_onehot == '0));

endmodule

// File: tb/test_wrr_sched.sv
`timescale 1ns/1ps
module test_wrr_sched;
    localparam int NQ = 4;
    localparam int QW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NQ-1:0] q_pending;
    logic          cfg_we;
    logic [QW-1:0] cfg_idx;
    logic [3:0]    cfg_code;
    logic          req;
    logic          gnt_valid;
    logic [NQ-1:0] gnt_onehot;
    logic [QW-1:0] gnt_idx;
    logic          cfg_err;

    always #2.5 clk = ~clk;

    wrr_sched #(.NQ(NQ)) i_wrr_sched (
        .clk(clk), .rst_n(rst_n), .q_pending(q_pending),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
        .req(req), .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot),
        .gnt_idx(gnt_idx), .cfg_err(cfg_err)
    );

    int total = 0;
    int bad   = 0;
    int m_r, m_s;
    logic [7:0] m_mask [NQ];
    logic       m_st   [NQ];
    int cnt [NQ];

    function automatic logic [7:0] mask_of(input int code);
        case (code)
            1: return 8'h01;  2: return 8'h11;  3: return 8'h49;
            4: return 8'h55;  5: return 8'h57;  6: return 8'h77;
            7: return 8'h7F;  8: return 8'hFF;  9: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; req = 1'b0; q_pending = '0;
        cfg_idx = '0; cfg_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_r = 0; m_s = 0;
        for (int i = 0; i < NQ; i++) begin m_mask[i] = 8'h00; m_st[i] = 1'b0; end
    endtask

    task automatic cfg(input int q, input int code, input string rq);
        bit exp_err;
        bit v [NQ];
        bit seen_gap;
        exp_err = (code > 9);
        for (int i = 0; i < NQ; i++) v[i] = m_st[i];
        v[q] = (code == 9);
        seen_gap = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (!v[i]) seen_gap = 1'b1;
            else if (seen_gap) exp_err = 1'b1;
        end
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = QW'(q); cfg_code = 4'(code);
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_err == exp_err, rq, int'(cfg_err), int'(exp_err));
        if (!exp_err) begin
            m_mask[q] = mask_of(code);
            m_st[q]   = (code == 9);
        end
    endtask

    function automatic int model_next(input logic [NQ-1:0] pend);
        for (int i = 0; i < NQ; i++)
            if (m_st[i] && pend[i]) return i;
        for (int k = 0; k < 9; k++) begin
            for (int q = m_s; q < NQ; q++) begin
                if (pend[q] && m_mask[q][m_r]) begin
                    m_s = q + 1;
                    if (m_s == NQ) begin m_s = 0; m_r = (m_r + 1) % 8; end
                    return q;
                end
            end
            m_r = (m_r + 1) % 8; m_s = 0;
        end
        return -1;
    endfunction

    task automatic run(input int n, input logic [NQ-1:0] pend, input string rq);
        int got = 0;
        int gap = 0;
        int e;
        for (int i = 0; i < NQ; i++) cnt[i] = 0;
        q_pending = pend;
        req = 1'b1;
        while (got < n && gap <= 40) begin
            @(negedge clk);
            gap++;
            if (gnt_valid) begin
                e = model_next(pend);
                check(int'(gnt_idx) == e, rq, int'(gnt_idx), e);
                check(gnt_onehot == NQ'(1) << e, "R10", int'(gnt_onehot), 1 << e);
                check(gap <= 12, "R8 grant gap", gap, 12);
                cnt[gnt_idx]++;
                got++;
                gap = 0;
            end
        end
        req = 1'b0;
        check(got == n, "R8 stalled", got, n);
    endtask

    task automatic idle_check(input int cycles, input bit hold_req, input string rq);
        int seen = 0;
        req = hold_req;
        repeat (cycles) begin
            @(negedge clk);
            if (gnt_valid) seen++;
        end
        req = 1'b0;
        check(seen == 0, rq, seen, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(gnt_valid == 1'b0, "R1 gnt_valid", int'(gnt_valid), 0);
        check(gnt_onehot == '0, "R1 gnt_onehot", int'(gnt_onehot), 0);
        check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
        q_pending = '1;
        idle_check(20, 1'b1, "R1 masks zero");

        // R2 R3 R4 weight sweep over eight rounds
        for (int w = 0; w <= 8; w++) begin
            do_reset();
            cfg(0, w, "R2 cfg"); cfg(1, 8 - w, "R2 cfg");
            cfg(2, 1, "R2 cfg"); cfg(3, 0, "R2 cfg");
            run(9, 4'b1111, "R2 order");
            check(cnt[0] == w, "R3 count q0", cnt[0], w);
            check(cnt[1] == 8 - w, "R3 count q1", cnt[1], 8 - w);
            check(cnt[2] == 1, "R3 count q2", cnt[2], 1);
            check(cnt[3] == 0, "R4 weight zero", cnt[3], 0);
        end

        // R2 R9 pending patterns with pauses
        do_reset();
        cfg(0, 3, "R2 cfg"); cfg(1, 5, "R2 cfg"); cfg(2, 7, "R2 cfg"); cfg(3, 2, "R2 cfg");
        run(17, 4'b1010, "R2 pattern 1010");
        idle_check(10, 1'b0, "R9 req low");
        run(23, 4'b0101, "R9 resume 0101");
        idle_check(7, 1'b0, "R9 req low");
        run(40, 4'b1111, "R2 pattern 1111");

        // R5 R6 static group
        do_reset();
        cfg(0, 9, "R6 cfg"); cfg(1, 9, "R6 cfg"); cfg(2, 4, "R6 cfg"); cfg(3, 8, "R6 cfg");
        run(6, 4'b1111, "R5 static q0");
        check(cnt[0] == 6, "R5 static q0 count", cnt[0], 6);
        run(6, 4'b1110, "R5 static q1");
        check(cnt[1] == 6, "R5 static q1 count", cnt[1], 6);
        run(14, 4'b1100, "R5 weighted after static");
        cfg(3, 9, "R6 gap rejected");
        cfg(0, 3, "R6 hole at q0 rejected");
        run(4, 4'b1001, "R6 config kept");
        cfg(1, 2, "R6 shrink group");
        cfg(0, 5, "R6 clear group");
        cfg(1, 9, "R6 not at q0 rejected");
        run(10, 4'b0010, "R6 q1 weight two");

        // R7 illegal codes
        for (int c = 10; c <= 15; c++) cfg(2, c, "R7 illegal code");
        run(12, 4'b1111, "R7 config kept");

        // R11 runtime weight change
        do_reset();
        for (int q = 0; q < NQ; q++) cfg(q, 1, "R11 cfg");
        run(3, 4'b1111, "R11 before change");
        cfg(3, 8, "R11 change");
        cfg(0, 0, "R11 change");
        run(20, 4'b1111, "R11 after change");

        // R8 empty rounds skipped
        do_reset();
        cfg(0, 1, "R8 cfg");
        run(4, 4'b0001, "R8 sparse rounds");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule